// File: doc/BRIEF.md
# Interrupt Vector and Acknowledge Controller

This block sits beside a small processor's program counter and call stack. It watches several interrupt event lines: one external pin and two timer overflows in the default build. It holds a pending flag for each line and decides on each clock whether one of them may be taken. When it takes an interrupt it emits a one-cycle acknowledge. The same pulse asks the stack to push the return address and tells the program counter to load the service address of that source.

Straight after reset the block also gives the start address, zero, with a program-counter load pulse. A request is taken only when its source enable is set, the global enable is set and the stack has room. A request that arrives while the stack is full stays pending. It is taken as soon as a return pops a level and the full indication drops. Taking an interrupt clears the global enable. A return-from-interrupt strobe sets it again, and software may also write it.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is held, and up to the first clock edge after reset is released, `pc_load_o` is 1, `vec_o` is 0x000 and `ack_o` is 0. All flags and the global enable reset to 0.
- R2: A 0-to-1 change of `evt_i[k]` sets `flag_o[k]` at the clock edge that samples the new level. An input held high sets the flag only once.
- R3: Source k is served at address 0x004 + 4·k. The external source is bit 0 (0x004), timer 0 is bit 1 (0x008) and timer 1 is bit 2 (0x00C). `vec_o` shows that address while `ack_o` is 1.
- R4: `ack_o` is 1 for exactly one cycle, and only in the cycle after an edge at which some flag k with `src_en_i[k]` = 1 was set, the global enable was 1, `stack_full_i` was 0 and reset had ended. `push_o` and `pc_load_o` are 1 in that same cycle, and `ack_src_o` is the one-hot source.
- R5: While `stack_full_i` is 1, no acknowledge follows and the pending flag is kept. After `stack_full_i` returns to 0, the pending request is acknowledged one cycle later.
- R6: When several enabled flags are pending, the lowest index wins: bit 0, then bit 1, then bit 2.
- R7: An acknowledge clears the global enable and the flag of the served source only. Other flags keep their value.
- R8: `reti_i` sets the global enable, and `gie_wr_i` loads it with `gie_wdata_i`. The clear caused by an acknowledge beats both, and a write beats `reti_i`.
- R9: `flag_clr_i[k]` clears flag k. A rising edge on `evt_i[k]` in the same cycle wins, and the flag stays set.
- R10: A flag whose source enable is 0 stays pending and causes no acknowledge. It is served once the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Raw interrupt event lines, bit 0 highest priority |
| src_en_i | input | NUM_SRC | Per-source enable |
| flag_clr_i | input | NUM_SRC | Software clear of pending flags |
| gie_wr_i | input | 1 | Write strobe for the global enable |
| gie_wdata_i | input | 1 | Value written to the global enable |
| reti_i | input | 1 | Return-from-interrupt strobe, sets the global enable |
| stack_full_i | input | 1 | Call stack has no free level |
| ack_o | output | 1 | Interrupt acknowledge pulse |
| push_o | output | 1 | Request to push the return address onto the stack |
| pc_load_o | output | 1 | Program counter loads `vec_o` |
| vec_o | output | PC_W | Reset or service address |
| ack_src_o | output | NUM_SRC | One-hot source of the current acknowledge |
| flag_o | output | NUM_SRC | Pending request flags |
| gie_o | output | 1 | Global interrupt enable |

## Verification
The hardest case to reach is a request that is held back and later released. The stimulus raises the full indication before the event edge and keeps it up for several cycles. It then drops the indication and expects the acknowledge one cycle later at the right address. Same-cycle collisions are also hard to reach: an acknowledge against a return strobe, and a software clear against a new edge. Both are reached by setting the global enable or the flag one cycle ahead, so that the two actions land on the same edge. Every mix of pending sources and enables is swept, with a return strobe after each acknowledge, so the order of service is checked against a priority computed in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;

   // Address served for source idx: base plus a fixed stride per source.
   function automatic int unsigned irq_vec_addr(input int unsigned idx,
                                                input int unsigned base,
                                                input int unsigned stride);
      return base + idx * stride;
   endfunction

   // Rule used for the global enable: lower enum value has higher precedence.
   typedef enum logic [1:0] {
      GIE_ACK_CLEAR = 2'd0,
      GIE_SW_WRITE  = 2'd1,
      GIE_RET_SET   = 2'd2,
      GIE_HOLD      = 2'd3
   } gie_op_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned NUM_SRC = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] sw_clr_i,
   input  logic [NUM_SRC-1:0] ack_clr_i,
   output logic [NUM_SRC-1:0] flag_o
);

   logic [NUM_SRC-1:0] evt_q;
   logic [NUM_SRC-1:0] rise;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_q <= '0;
      else         evt_q <= evt_i;
   end

   assign rise = evt_i & ~evt_q;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      logic flag_q;
      logic flag_d;

      // A fresh edge wins over any clear in the same cycle.
      always_comb begin
         flag_d = flag_q;
         if (sw_clr_i[k] || ack_clr_i[k]) flag_d = 1'b0;
         if (rise[k])                     flag_d = 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) flag_q <= 1'b0;
         else         flag_q <= flag_d;
      end

      assign flag_o[k] = flag_q;
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NUM_SRC = 3
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic [NUM_SRC-1:0] grant_o,
   output logic               any_o
);

   // blocked[k] is set when some lower index is requesting.
   logic [NUM_SRC:0] blocked;

   assign blocked[0] = 1'b0;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_chain
      assign blocked[k+1] = blocked[k] | req_i[k];
      assign grant_o[k]   = req_i[k] & ~blocked[k];
   end

   assign any_o = blocked[NUM_SRC];

endmodule

// File: rtl/irq_vec_rom.sv
module irq_vec_rom
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 3,
   parameter int unsigned PC_W       = 13,
   parameter int unsigned VEC_BASE   = 4,
   parameter int unsigned VEC_STRIDE = 4
) (
   input  logic [NUM_SRC-1:0] grant_i,
   output logic [PC_W-1:0]    vec_o
);

   // Partial OR chain over the one-hot grant.
   logic [PC_W-1:0] part [NUM_SRC+1];

   assign part[0] = '0;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_entry
      localparam int unsigned    ADDR_INT = irq_vec_addr(k, VEC_BASE, VEC_STRIDE);
      localparam logic [PC_W-1:0] ADDR    = PC_W'(ADDR_INT);
      assign part[k+1] = part[k] | (grant_i[k] ? ADDR : '0);
   end

   assign vec_o = part[NUM_SRC];

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 3,
   parameter int unsigned PC_W       = 13,
   parameter int unsigned VEC_BASE   = 4,
   parameter int unsigned VEC_STRIDE = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] src_en_i,
   input  logic [NUM_SRC-1:0] flag_clr_i,
   input  logic               gie_wr_i,
   input  logic               gie_wdata_i,
   input  logic               reti_i,
   input  logic               stack_full_i,
   output logic               ack_o,
   output logic               push_o,
   output logic               pc_load_o,
   output logic [PC_W-1:0]    vec_o,
   output logic [NUM_SRC-1:0] ack_src_o,
   output logic [NUM_SRC-1:0] flag_o,
   output logic               gie_o
);

   localparam int unsigned LAST_VEC = irq_vec_addr(NUM_SRC - 1, VEC_BASE, VEC_STRIDE);

   // Parameter checks made at elaboration time.
   if (NUM_SRC < 1) begin : g_bad_num
      $error("irq_vector_ctrl: NUM_SRC must be at least 1");
   end
   if (VEC_STRIDE < 1) begin : g_bad_stride
      $error("irq_vector_ctrl: VEC_STRIDE must be at least 1");
   end
   if (VEC_BASE == 0) begin : g_bad_base
      $error("irq_vector_ctrl: VEC_BASE may not collide with the reset address");
   end
   if (PC_W < 2 || PC_W > 31 || LAST_VEC >= (32'd1 << PC_W)) begin : g_bad_width
      $error("irq_vector_ctrl: PC_W too narrow for the vector table");
   end

   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] eligible;
   logic [NUM_SRC-1:0] grant;
   logic               any_req;
   logic               take;
   logic [NUM_SRC-1:0] ack_clr;
   logic [PC_W-1:0]    vec_sel;

   logic               boot_q;
   logic               ack_q;
   logic               gie_q;
   logic [PC_W-1:0]    vec_q;
   logic [NUM_SRC-1:0] src_q;
   gie_op_e            gie_op;

   irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i),
      .sw_clr_i  (flag_clr_i),
      .ack_clr_i (ack_clr),
      .flag_o    (flags)
   );

   assign eligible = flags & src_en_i;

   irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .req_i   (eligible),
      .grant_o (grant),
      .any_o   (any_req)
   );

   irq_vec_rom #(
      .NUM_SRC    (NUM_SRC),
      .PC_W       (PC_W),
      .VEC_BASE   (VEC_BASE),
      .VEC_STRIDE (VEC_STRIDE)
   ) u_rom (
      .grant_i (grant),
      .vec_o   (vec_sel)
   );

   // Take only with room on the stack, the global enable set and reset over.
   assign take    = any_req & gie_q & ~stack_full_i & ~boot_q;
   assign ack_clr = take ? grant : '0;

   always_comb begin
      if (take)          gie_op = GIE_ACK_CLEAR;
      else if (gie_wr_i) gie_op = GIE_SW_WRITE;
      else if (reti_i)   gie_op = GIE_RET_SET;
      else               gie_op = GIE_HOLD;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gie_q <= 1'b0;
      end else begin
         unique case (gie_op)
            GIE_ACK_CLEAR: gie_q <= 1'b0;
            GIE_SW_WRITE:  gie_q <= gie_wdata_i;
            GIE_RET_SET:   gie_q <= 1'b1;
            default:       gie_q <= gie_q;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         boot_q <= 1'b1;
         ack_q  <= 1'b0;
         vec_q  <= '0;
         src_q  <= '0;
      end else begin
         boot_q <= 1'b0;
         ack_q  <= take;
         src_q  <= ack_clr;
         if (take) vec_q <= vec_sel;
      end
   end

   assign ack_o     = ack_q;
   assign push_o    = ack_q;
   assign pc_load_o = boot_q | ack_q;
   assign vec_o     = vec_q;
   assign ack_src_o = src_q;
   assign flag_o    = flags;
   assign gie_o     = gie_q;

endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
   parameter int unsigned NUM_SRC    = 3,
   parameter int unsigned PC_W       = 13,
   parameter int unsigned VEC_BASE   = 4,
   parameter int unsigned VEC_STRIDE = 4
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_SRC-1:0] src_en_i,
   input logic               stack_full_i,
   input logic               ack_o,
   input logic               push_o,
   input logic               pc_load_o,
   input logic [PC_W-1:0]    vec_o,
   input logic [NUM_SRC-1:0] ack_src_o,
   input logic [NUM_SRC-1:0] flag_o,
   input logic               gie_o
);

   p_push_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_o |-> (ack_o && pc_load_o && $countones(ack_src_o) == 1));

   p_ack_needs_room_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |-> ($past(gie_o) && !$past(stack_full_i)));

   p_full_blocks_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stack_full_i |=> !ack_o);

   p_ack_drops_gie_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |-> !gie_o);

   p_boot_vec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pc_load_o && !ack_o) |-> (vec_o == '0));

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      localparam logic [PC_W-1:0] ADDR = PC_W'(VEC_BASE + k * VEC_STRIDE);

      p_vec_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ack_src_o[k] |-> (vec_o == ADDR));

      p_served_was_enabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ack_src_o[k] |-> ($past(flag_o[k]) && $past(src_en_i[k])));

      if (k > 0) begin : g_prio
         localparam logic [NUM_SRC-1:0] LOWER = NUM_SRC'((1 << k) - 1);
         p_prio_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ack_src_o[k] |-> (($past(flag_o & src_en_i) & LOWER) == '0));
      end
   end

endmodule

bind irq_vector_ctrl irq_vector_chk #(
   .NUM_SRC    (NUM_SRC),
   .PC_W       (PC_W),
   .VEC_BASE   (VEC_BASE),
   .VEC_STRIDE (VEC_STRIDE)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .src_en_i     (src_en_i),
   .stack_full_i (stack_full_i),
   .ack_o        (ack_o),
   .push_o       (push_o),
   .pc_load_o    (pc_load_o),
   .vec_o        (vec_o),
   .ack_src_o    (ack_src_o),
   .flag_o       (flag_o),
   .gie_o        (gie_o)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

   localparam int N  = 3;
   localparam int PW = 13;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  evt, src_en, flag_clr, ack_src, flag;
   logic          gie_wr, gie_wd, reti, stack_full;
   logic          ack, push, pc_load, gie;
   logic [PW-1:0] vec;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   irq_vector_ctrl #(.NUM_SRC(N), .PC_W(PW), .VEC_BASE(4), .VEC_STRIDE(4)) i_irq_vector_ctrl (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .evt_i        (evt),
      .src_en_i     (src_en),
      .flag_clr_i   (flag_clr),
      .gie_wr_i     (gie_wr),
      .gie_wdata_i  (gie_wd),
      .reti_i       (reti),
      .stack_full_i (stack_full),
      .ack_o        (ack),
      .push_o       (push),
      .pc_load_o    (pc_load),
      .vec_o        (vec),
      .ack_src_o    (ack_src),
      .flag_o       (flag),
      .gie_o        (gie)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic reti_pulse();
      reti = 1'b1;
      step();
      reti = 1'b0;
   endtask

   function automatic int lowest(input int m);
      for (int b = 0; b < N; b++) if (m[b]) return b;
      return -1;
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #400000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; evt = '0; src_en = '0; flag_clr = '0;
      gie_wr = 1'b0; gie_wd = 1'b0; reti = 1'b0; stack_full = 1'b0;
      repeat (3) step();
      // R1 reset state
      chk("R1 pc_load in reset", 32'(pc_load), 1);
      chk("R1 vec in reset", 32'(vec), 0);
      chk("R1 ack in reset", 32'(ack), 0);
      chk("R1 flags in reset", 32'(flag), 0);
      chk("R1 gie in reset", 32'(gie), 0);
      rst_n = 1'b1;
      #1;
      chk("R1 pc_load after release", 32'(pc_load), 1);
      chk("R1 vec after release", 32'(vec), 0);
      step();
      chk("R1 pc_load single cycle", 32'(pc_load), 0);
      chk("R1 no ack at boot", 32'(ack), 0);

      // Sweep: every enable mask against every pending set
      for (int en = 0; en < (1 << N); en++) begin
         for (int pat = 1; pat < (1 << N); pat++) begin
            int rem;
            src_en = N'(en); evt = N'(pat); gie_wr = 1'b1; gie_wd = 1'b1;
            step();
            evt = '0; gie_wr = 1'b0;
            chk("R2 flags latched", 32'(flag), 32'(pat));
            chk("R4 no early ack", 32'(ack), 0);
            rem = pat;
            step();
            while ((rem & en) != 0) begin
               int b;
               b = lowest(rem & en);
               chk("R6 ack in priority order", 32'(ack), 1);
               chk("R6 ack source", 32'(ack_src), 32'(1 << b));
               chk("R3 vector", 32'(vec), 32'(4 + 4 * b));
               chk("R4 push with ack", 32'(push), 1);
               chk("R7 served flag cleared", 32'(flag), 32'(rem & ~(1 << b)));
               chk("R7 gie cleared", 32'(gie), 0);
               rem = rem & ~(1 << b);
               reti_pulse();
               chk("R8 reti sets gie", 32'(gie), 1);
               chk("R4 single cycle ack", 32'(ack), 0);
               step();
            end
            chk("R10 masked not served", 32'(ack), 0);
            chk("R10 masked stays pending", 32'(flag), 32'(rem));
            flag_clr = N'(rem); gie_wr = 1'b1; gie_wd = 1'b0;
            step();
            flag_clr = '0; gie_wr = 1'b0;
            chk("R9 software clear", 32'(flag), 0);
            chk("R8 write clears gie", 32'(gie), 0);
         end
      end

      // R5 stack full holds the request
      src_en = '1; gie_wr = 1'b1; gie_wd = 1'b1; stack_full = 1'b1; evt = 3'b010;
      step();
      gie_wr = 1'b0; evt = '0;
      for (int i = 0; i < 4; i++) begin
         step();
         chk("R5 flag held while full", 32'(flag), 32'h2);
         chk("R5 no ack while full", 32'(ack), 0);
      end
      stack_full = 1'b0;
      step();
      chk("R5 ack after room", 32'(ack), 1);
      chk("R5 vector after room", 32'(vec), 32'h8);
      chk("R5 flag cleared", 32'(flag), 0);
      reti_pulse();

      // R2 held level sets only once
      evt = 3'b001;
      step();
      chk("R2 level edge sets", 32'(flag), 1);
      step();
      chk("R2 ack on edge", 32'(ack), 1);
      chk("R3 external vector", 32'(vec), 32'h4);
      reti_pulse();
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R2 held level no reset of flag", 32'(flag), 0);
         chk("R2 held level no ack", 32'(ack), 0);
      end
      evt = '0;
      step();
      evt = 3'b001;
      step();
      chk("R2 new edge sets again", 32'(flag), 1);
      step();
      chk("R2 second ack", 32'(ack), 1);
      evt = '0;
      reti_pulse();

      // R9 edge beats clear in the same cycle
      gie_wr = 1'b1; gie_wd = 1'b0;
      step();
      gie_wr = 1'b0;
      evt = 3'b100;
      step();
      chk("R9 flag set", 32'(flag), 32'h4);
      evt = '0;
      step();
      evt = 3'b100; flag_clr = 3'b100;
      step();
      flag_clr = '0;
      chk("R9 edge wins over clear", 32'(flag), 32'h4);
      flag_clr = 3'b100;
      step();
      flag_clr = '0; evt = '0;
      chk("R9 clear alone", 32'(flag), 0);

      // R8 acknowledge beats reti
      evt = 3'b001;
      step();
      evt = '0;
      step();
      chk("R4 gie off blocks ack", 32'(ack), 0);
      chk("R4 flag pending", 32'(flag), 1);
      gie_wr = 1'b1; gie_wd = 1'b1;
      step();
      gie_wr = 1'b0;
      chk("R8 write sets gie", 32'(gie), 1);
      reti = 1'b1;
      step();
      reti = 1'b0;
      chk("R8 ack with reti", 32'(ack), 1);
      chk("R8 ack clear beats reti", 32'(gie), 0);
      reti_pulse();
      chk("R8 reti restores gie", 32'(gie), 1);

      // R10 disabled source served after enable
      src_en = '0; evt = 3'b010;
      step();
      evt = '0;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R10 disabled pending", 32'(flag), 32'h2);
         chk("R10 disabled no ack", 32'(ack), 0);
      end
      src_en = 3'b010;
      step();
      chk("R10 served after enable", 32'(ack), 1);
      chk("R10 vector", 32'(vec), 32'h8);
      chk("R10 flag cleared", 32'(flag), 0);
      reti_pulse();

      finish_run();
   end

endmodule